// File: doc/BRIEF.md
# FIFO Level Trigger Generator

This block holds two first-in first-out queues, one for data to be sent and one for data that has arrived, and raises a level trigger for each of them when its occupancy crosses a programmable point. A 32-bit control word enables each trigger and sets its threshold. Each trigger can then drive a shared interrupt line, and it can drive a direct-memory-access request line for its own direction. Both routings are selected by enable pins.

The two thresholds count in different ways. The send-side threshold N fires while the queue holds N entries or fewer, so 0 means "drained". The receive-side threshold N fires once the queue holds N+1 entries or more, so 0 means "holds something". The receive trigger is raised only when an entry is actually written into the receive queue. The send trigger follows the occupancy at all times.

Top module: `fifo_lvl_trig`

## Requirements
- R1: After reset the control word reads 0, both occupancies are 0, and every trigger, interrupt, request and error output is low.
- R2: A control write stores bit 0 (send trigger enable), bit 1 (receive trigger enable), bits 11:8 (send threshold) and bits 19:16 (receive threshold). Every other bit reads 0 whatever was written. The new value is visible on the read port one cycle after the write.
- R3: Each queue is 16 deep and returns entries in the order they were pushed. The head entry is shown on the read-data port while the queue is not empty. The occupancy output changes by +1 for an accepted push, by -1 for an accepted pop, and by 0 when both happen in the same cycle.
- R4: A push while the queue holds 16 entries, or a pop while it holds 0, leaves the queue unchanged and raises that queue's error output for exactly the next cycle.
- R5: While bit 0 is set, the send trigger is high exactly when the send occupancy is at or below the send threshold. This is evaluated on every cycle.
- R6: While bit 1 is set, an accepted receive push sets the receive trigger, one cycle later, to whether the new occupancy is at least threshold+1. A pop that brings the occupancy below threshold+1 clears it. Changing the threshold or the enable never raises it without a push.
- R7: While its enable bit is 0, a trigger stays low and its threshold field has no effect.
- R8: The interrupt output is high when the send trigger is high with irq_en[0] set, or when the receive trigger is high with irq_en[1] set.
- R9: dma_tx_req equals the send trigger gated by dma_en[0], and dma_rx_req equals the receive trigger gated by dma_en[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| irq_en | input | 2 | Interrupt routing enable, bit 0 send, bit 1 receive |
| dma_en | input | 2 | Request routing enable, bit 0 send, bit 1 receive |
| tx_push | input | 1 | Push into send queue |
| tx_wdata | input | 8 | Send queue push data |
| tx_pop | input | 1 | Pop from send queue |
| tx_rdata | output | 8 | Send queue head entry |
| tx_count | output | 5 | Send queue occupancy |
| tx_err | output | 1 | Send queue overflow or underflow pulse |
| rx_push | input | 1 | Push into receive queue |
| rx_wdata | input | 8 | Receive queue push data |
| rx_pop | input | 1 | Pop from receive queue |
| rx_rdata | output | 8 | Receive queue head entry |
| rx_count | output | 5 | Receive queue occupancy |
| rx_err | output | 1 | Receive queue overflow or underflow pulse |
| tx_trig | output | 1 | Send level trigger |
| rx_trig | output | 1 | Receive level trigger |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Send request |
| dma_rx_req | output | 1 | Receive request |

## Verification
The bench uses the default parameters: 8-bit data and a depth of 16, so the threshold fields are a full 4 bits wide. With this depth, every threshold value from 0 to 15 maps to an occupancy the queues can actually reach. Traffic that is biased toward filling and then toward draining pushes both queues to full and to empty many times. This exercises both extreme thresholds, the overflow and underflow pulses, and receive threshold rewrites that occur between pushes.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
    localparam int CTRL_W     = 32;
    localparam int TX_EN_BIT  = 0;
    localparam int RX_EN_BIT  = 1;
    localparam int TX_THR_LSB = 8;
    localparam int RX_THR_LSB = 16;
    localparam int THR_SPAN   = 8;

    function automatic logic [CTRL_W-1:0] ctrl_mask(input int thr_w);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[TX_EN_BIT] = 1'b1;
        m[RX_EN_BIT] = 1'b1;
        for (int i = 0; i < thr_w; i++) begin
            m[TX_THR_LSB+i] = 1'b1;
            m[RX_THR_LSB+i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/fifo_lvl_ctrl.sv
module fifo_lvl_ctrl
    import fifo_lvl_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic              tx_en,
    output logic              rx_en,
    output logic [THR_W-1:0]  tx_thr,
    output logic [THR_W-1:0]  rx_thr
);
    localparam logic [CTRL_W-1:0] MASK = ctrl_mask(THR_W);

    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.word = wdata & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.word;
    assign tx_en  = st_q.word[TX_EN_BIT];
    assign rx_en  = st_q.word[RX_EN_BIT];
    assign tx_thr = st_q.word[TX_THR_LSB +: THR_W];
    assign rx_thr = st_q.word[RX_THR_LSB +: THR_W];
endmodule

// File: rtl/fifo_lvl_queue.sv
module fifo_lvl_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              err
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d     = st_q;
        st_d.err = (push && full) || (pop && empty);
        if (push_ok) st_d.wptr = bump(st_q.wptr);
        if (pop_ok)  st_d.rptr = bump(st_q.rptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wptr] <= wdata;
    end

    assign rdata = mem[st_q.rptr];
    assign count = st_q.cnt;
    assign err   = st_q.err;
endmodule

// File: rtl/fifo_lvl_eval.sv
module fifo_lvl_eval #(
    parameter int DEPTH  = 16,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push_ok,
    input  logic             rx_pop_ok,
    output logic             tx_trig,
    output logic             rx_trig
);
    typedef struct packed {
        logic rx_hit;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W:0] rx_next;
    logic [CNT_W:0] rx_mark;

    always_comb begin
        st_d    = st_q;
        rx_next = {1'b0, rx_count} + (CNT_W+1)'(rx_push_ok) - (CNT_W+1)'(rx_pop_ok);
        rx_mark = (CNT_W+1)'(rx_thr) + 1'b1;
        if (!rx_en)                           st_d.rx_hit = 1'b0;
        else if (rx_push_ok)                  st_d.rx_hit = (rx_next >= rx_mark);
        else if (rx_pop_ok && rx_next < rx_mark) st_d.rx_hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_trig = tx_en && (tx_count <= CNT_W'(tx_thr));
    assign rx_trig = st_q.rx_hit;
endmodule

// File: rtl/fifo_lvl_trig.sv
module fifo_lvl_trig
    import fifo_lvl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        irq_en,
    input  logic [1:0]        dma_en,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_err,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_err,
    output logic              tx_trig,
    output logic              rx_trig,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    logic tx_en, rx_en;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

    fifo_lvl_ctrl #(.THR_W(THR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .rdata(reg_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .tx_thr(tx_thr), .rx_thr(rx_thr)
    );

    fifo_lvl_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_rdata), .count(tx_count),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .err(tx_err)
    );

    fifo_lvl_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .count(rx_count),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .err(rx_err)
    );

    fifo_lvl_eval #(.DEPTH(DEPTH)) u_eval (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_count(tx_count),
        .rx_count(rx_count), .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
        .tx_trig(tx_trig), .rx_trig(rx_trig)
    );

    assign irq        = (tx_trig && irq_en[0]) || (rx_trig && irq_en[1]);
    assign dma_tx_req = tx_trig && dma_en[0];
    assign dma_rx_req = rx_trig && dma_en[1];
endmodule

// File: rtl/fifo_lvl_trig_chk.sv
module fifo_lvl_trig_chk
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      reg_rdata,
    input logic [1:0]       irq_en,
    input logic [1:0]       dma_en,
    input logic             tx_push,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_err,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_err,
    input logic             tx_trig,
    input logic             rx_trig,
    input logic             irq,
    input logic             dma_tx_req
);
    localparam logic [31:0] MASK = ctrl_mask(THR_W);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~MASK) == '0);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    p_full_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_pop && tx_count == CNT_W'(DEPTH)) |=> (tx_err && tx_count == CNT_W'(DEPTH)));

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_count == '0) |=> (rx_err && rx_count == '0));

    p_tx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trig |-> (reg_rdata[TX_EN_BIT] && tx_count <= CNT_W'(reg_rdata[TX_THR_LSB +: THR_W])));

    p_rx_rise_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_trig) |-> $past(rx_push));

    p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[RX_EN_BIT] |=> !rx_trig);

    p_irq_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((tx_trig && irq_en[0]) || (rx_trig && irq_en[1])));

    p_dma_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> (tx_trig && dma_en[0]));
endmodule

bind fifo_lvl_trig fifo_lvl_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .irq_en(irq_en),
    .dma_en(dma_en), .tx_push(tx_push), .tx_pop(tx_pop), .tx_count(tx_count),
    .tx_err(tx_err), .rx_push(rx_push), .rx_pop(rx_pop), .rx_count(rx_count),
    .rx_err(rx_err), .tx_trig(tx_trig), .rx_trig(rx_trig), .irq(irq),
    .dma_tx_req(dma_tx_req)
);

// File: tb/fifo_lvl_trig_tb.sv
module fifo_lvl_trig_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq_en = '0, dma_en = '0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic [4:0]  tx_count, rx_count;
    logic        tx_err, rx_err, tx_trig, rx_trig, irq, dma_tx_req, dma_rx_req;

    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    fifo_lvl_trig u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_en(irq_en), .dma_en(dma_en),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_err(tx_err),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_err(rx_err),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          tq[$], rq[$];
    logic [31:0] m_reg = '0;
    bit          m_terr = 0, m_rerr = 0, m_rtrig = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            tq.delete(); rq.delete();
            m_reg = '0; m_terr = 0; m_rerr = 0; m_rtrig = 0;
        end else begin
            bit tpu, tpo, rpu, rpo;
            int rthr;
            tpu = tx_push && tq.size() < 16;
            tpo = tx_pop && tq.size() > 0;
            rpu = rx_push && rq.size() < 16;
            rpo = rx_pop && rq.size() > 0;
            m_terr = (tx_push && tq.size() == 16) || (tx_pop && tq.size() == 0);
            m_rerr = (rx_push && rq.size() == 16) || (rx_pop && rq.size() == 0);
            if (tpo) void'(tq.pop_front());
            if (tpu) tq.push_back(int'(tx_wdata));
            if (rpo) void'(rq.pop_front());
            if (rpu) rq.push_back(int'(rx_wdata));
            rthr = int'(m_reg[19:16]);
            if (!m_reg[1])                           m_rtrig = 0;
            else if (rpu)                            m_rtrig = (rq.size() >= rthr + 1);
            else if (rpo && rq.size() < rthr + 1)    m_rtrig = 0;
            if (reg_we) m_reg = reg_wdata & 32'h000F0F03;
        end
        #2;
        if (rst_n) begin
            bit et;
            et = m_reg[0] && (tq.size() <= int'(m_reg[11:8]));
            chk("R2", "reg_rdata", reg_rdata, m_reg);
            chk("R3", "tx_count", 32'(tx_count), 32'(tq.size()));
            chk("R3", "rx_count", 32'(rx_count), 32'(rq.size()));
            if (tq.size() > 0) chk("R3", "tx_rdata", 32'(tx_rdata), 32'(tq[0]));
            if (rq.size() > 0) chk("R3", "rx_rdata", 32'(rx_rdata), 32'(rq[0]));
            chk("R4", "tx_err", 32'(tx_err), 32'(m_terr));
            chk("R4", "rx_err", 32'(rx_err), 32'(m_rerr));
            chk("R5", "tx_trig", 32'(tx_trig), 32'(et));
            chk("R6", "rx_trig", 32'(rx_trig), 32'(m_rtrig));
            chk("R8", "irq", 32'(irq), 32'((et && irq_en[0]) || (m_rtrig && irq_en[1])));
            chk("R9", "dma_tx_req", 32'(dma_tx_req), 32'(et && dma_en[0]));
            chk("R9", "dma_rx_req", 32'(dma_rx_req), 32'(m_rtrig && dma_en[1]));
        end
    end

    task automatic step(input bit tp, input bit tpo, input bit rp, input bit rpo,
                        input bit we, input logic [31:0] wd);
        @(negedge clk);
        tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
        tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
        reg_we = we; reg_wdata = wd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "reg_rdata", reg_rdata, 32'h0);
        chk("R1", "counts", 32'({tx_count, rx_count}), 32'h0);
        chk("R1", "outputs", 32'({tx_trig, rx_trig, irq, dma_tx_req, dma_rx_req, tx_err, rx_err}), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        irq_en = 2'b11; dma_en = 2'b11;
        // R2: only defined bits stick
        step(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 0, 0);
        @(posedge clk); #3;
        chk("R2", "mask", reg_rdata, 32'h000F_0F03);
        // R7: thresholds without enable do nothing
        step(0, 0, 0, 0, 1, 32'h000F_0F00);
        repeat (3) step(1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        @(posedge clk); #3;
        chk("R7", "tx_trig disabled", 32'(tx_trig), 32'h0);
        chk("R7", "rx_trig disabled", 32'(rx_trig), 32'h0);
        // R6: enabling with 3 queued entries does not raise without a push
        step(0, 0, 0, 0, 1, 32'h0000_0002);
        repeat (2) step(0, 0, 0, 0, 0, 0);
        @(posedge clk); #3;
        chk("R6", "no rise on enable", 32'(rx_trig), 32'h0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        @(posedge clk); #3;
        chk("R6", "rise on push", 32'(rx_trig), 32'h1);
        // R4/R3: fill and drain both queues past their limits
        repeat (18) step(1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 32'h000A_0F03);
        repeat (18) step(0, 1, 0, 1, 0, 0);
        // R6: threshold rewrite between pushes
        repeat (3) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 32'h0000_0002);
        repeat (2) step(0, 0, 0, 0, 0, 0);
        // mixed traffic with fill/drain bias and random control writes
        for (int i = 0; i < 4000; i++) begin
            int bias;
            bias = ((i / 200) % 2 == 0) ? 75 : 25;
            if (i % 64 == 0) begin
                irq_en = 2'($urandom); dma_en = 2'($urandom);
            end
            step($urandom_range(99) < bias, $urandom_range(99) >= bias,
                 $urandom_range(99) < bias, $urandom_range(99) >= bias,
                 $urandom_range(99) < 4, $urandom);
        end
        step(0, 0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule